// File: doc/BRIEF.md
# DAC Serial Command Writer

This block sits on the host side of a board-level link to a dual 10-bit voltage DAC. A requester hands it one command at a time: a 4-bit operation code and a 10-bit sample value, offered with a valid/ready handshake. The block packs these into a 16-bit word and sends it over three wires: an active-low select/load strobe, a serial clock and a serial data line. All three are generated from the system clock.

The spacing between every pair of interface edges is derived from nanosecond timing parameters and the system clock period. Each delay is rounded up to whole cycles. This covers select-to-clock lead, data setup, clock high and low phases, minimum clock period, last-clock-to-load delay and the load pulse width. Data changes only while the serial clock is low. The DAC latches data on each rising clock edge and acts on the word when select returns high. The block becomes ready again once the minimum load-high time has passed, and it flags completion with a one-cycle pulse at that point.

Top module: `dac_serial_master`

## Requirements
- R1: After a synchronous active-low reset, select is high, the serial clock and data lines are low, ready is high and done is low.
- R2: Each frame carries exactly 16 rising clock edges. Data sampled on these edges is, in order: operation code bits 3 down to 0, then value bits 9 down to 0, then two zero bits.
- R3: The serial clock is low whenever select falls and whenever select is high, so it toggles only inside a frame.
- R4: At least 30 ns pass from select falling to the first rising clock edge. The data line is stable for at least 60 ns before every rising clock edge.
- R5: Every clock high phase and every clock low phase inside a frame lasts at least 50 ns. Successive rising edges are at least 100 ns apart.
- R6: At least 50 ns pass from the last rising clock edge of a frame to select going high.
- R7: Select stays high for at least 100 ns between consecutive frames.
- R8: A request is taken on a clock edge where valid and ready are both high, and the opcode and value are captured on that edge. Ready then stays low until the load-high time has passed. Request inputs that change while ready is low have no effect on the frame being sent.
- R9: Done is high for exactly one cycle, in the first cycle in which ready is high again after a frame.
- R10: With the default 20 ns clock period, the block follows a fixed schedule. Select falls on the accept edge. Clock rises 3 cycles later, with 3-cycle high and 3-cycle low phases. Select rises 1 cycle after the last falling clock edge. Ready returns 5 cycles after that. A request held valid is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 4 | Operation code, sent first |
| req_code | input | 10 | DAC sample value |
| done | output | 1 | One-cycle pulse at end of a frame |
| dac_sel_n | output | 1 | Select/load strobe, active low |
| dac_sck | output | 1 | Serial clock to the DAC |
| dac_sdo | output | 1 | Serial data to the DAC |

## Verification
The bench targets four kinds of fault. First, requests held valid back to back; a writer that shortens the load-high gap would show select dropping too early. Second, opcode and value inputs scrambled mid-frame while ready is low; a writer that samples late would send the scrambled bits. Third, all-ones and all-zeros values, which expose a bit order that is off by one or reversed. Fourth, the minimum spacing on either side of the first and last clock edges, where an off-by-one phase count would show up as a short lead, a short final high phase or a load strobe that comes too soon.

// File: rtl/dacw_pkg.sv
// Shared definitions for the DAC serial writer.
// Assumes all timing values are positive nanosecond figures.
package dacw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } wr_state_t;

    // Ceiling division giving at least one cycle.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacw_timer.sv
// Phase timer: loads a cycle count and counts down to zero.
// Assumes the caller reloads it on each phase entry; expired is high at zero.
module dacw_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dacw_shifter.sv
// Frame shift register: loads the packed word, shifts out MSB first.
// Assumes load, shift and clr are never asserted together.
module dacw_shifter #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] word,
    input  logic         shift,
    input  logic         clr,
    output logic         msb
);
    logic [N-1:0] sh_q;

    // Hold the word under transmission; zeros fill from below.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sh_q <= '0;
        else if (load)
            sh_q <= word;
        else if (shift)
            sh_q <= {sh_q[N-2:0], 1'b0};
    end

    assign msb = sh_q[N-1];
endmodule

// File: rtl/dac_serial_master.sv
// DAC serial command writer. Takes one opcode/value request through
// valid/ready, then drives select, clock and data with every edge pair
// spaced by cycle counts derived from nanosecond limits.
// Assumes CLK_NS is the system clock period; data moves on falling clock.
module dac_serial_master #(
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned OP_W      = 4,
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned PAD_W     = 2,
    parameter int unsigned T_SEL_CK  = 30,
    parameter int unsigned T_SETUP   = 60,
    parameter int unsigned T_CK_HI   = 50,
    parameter int unsigned T_CK_LO   = 50,
    parameter int unsigned T_CK_PER  = 100,
    parameter int unsigned T_LAST_LD = 50,
    parameter int unsigned T_LD_PW   = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [CODE_W-1:0] req_code,
    output logic              done,
    output logic              dac_sel_n,
    output logic              dac_sck,
    output logic              dac_sdo
);
    import dacw_pkg::*;

    localparam int unsigned WORD_W = OP_W + CODE_W + PAD_W;
    localparam int unsigned LO_CYC = umax(cyc_of(T_CK_LO, CLK_NS), cyc_of(T_SETUP, CLK_NS));
    localparam int unsigned LEAD_CYC = umax(cyc_of(T_SEL_CK, CLK_NS), LO_CYC);
    localparam int unsigned PER_CYC = cyc_of(T_CK_PER, CLK_NS);
    localparam int unsigned HI_CYC = umax(cyc_of(T_CK_HI, CLK_NS),
                                          (PER_CYC > LO_CYC) ? PER_CYC - LO_CYC : 1);
    localparam int unsigned LAST_CYC = cyc_of(T_LAST_LD, CLK_NS);
    localparam int unsigned TAIL_CYC = (LAST_CYC > HI_CYC) ? LAST_CYC - HI_CYC : 1;
    localparam int unsigned GAP_CYC = cyc_of(T_LD_PW, CLK_NS);
    localparam int unsigned MAX_CYC = umax(umax(LEAD_CYC, HI_CYC),
                                           umax(umax(LO_CYC, TAIL_CYC), GAP_CYC));
    localparam int unsigned TW = $clog2(MAX_CYC + 1);
    localparam int unsigned BW = $clog2(WORD_W);

    wr_state_t     state_q;
    logic [BW-1:0] bit_q;
    logic          sel_q, sck_q, done_q;
    logic          accept, last_bit, tmr_exp, tmr_load;
    logic [TW-1:0] tmr_val;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign last_bit = (bit_q == BW'(WORD_W - 1));

    // Pick the length of the phase that the next transition enters.
    always_comb begin
        tmr_load = accept || (state_q != ST_IDLE && state_q != ST_GAP && tmr_exp);
        case (state_q)
            ST_IDLE: tmr_val = TW'(LEAD_CYC - 1);
            ST_LEAD: tmr_val = TW'(HI_CYC - 1);
            ST_HIGH: tmr_val = last_bit ? TW'(TAIL_CYC - 1) : TW'(LO_CYC - 1);
            ST_LOW:  tmr_val = TW'(HI_CYC - 1);
            ST_TAIL: tmr_val = TW'(GAP_CYC - 1);
            default: tmr_val = '0;
        endcase
    end

    dacw_timer #(.W(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dacw_shifter #(.N(WORD_W)) shf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .word  ({req_op, req_code, {PAD_W{1'b0}}}),
        .shift (state_q == ST_HIGH && tmr_exp && !last_bit),
        .clr   (state_q == ST_TAIL && tmr_exp),
        .msb   (dac_sdo)
    );

    // Frame sequencer: walks the phases and drives the strobe lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sel_q   <= 1'b1;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    done_q <= 1'b0;
                    if (req_valid) begin
                        state_q <= ST_LEAD;
                        sel_q   <= 1'b0;
                        bit_q   <= '0;
                    end
                end
                ST_LEAD: if (tmr_exp) begin
                    state_q <= ST_HIGH;
                    sck_q   <= 1'b1;
                end
                ST_HIGH: if (tmr_exp) begin
                    sck_q <= 1'b0;
                    if (last_bit) begin
                        state_q <= ST_TAIL;
                    end else begin
                        state_q <= ST_LOW;
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                ST_LOW: if (tmr_exp) begin
                    state_q <= ST_HIGH;
                    sck_q   <= 1'b1;
                end
                ST_TAIL: if (tmr_exp) begin
                    state_q <= ST_GAP;
                    sel_q   <= 1'b1;
                end
                ST_GAP: if (tmr_exp) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign dac_sel_n = sel_q;
    assign dac_sck   = sck_q;

    // Run-length counters used only by the timing assertions below.
    logic [TW-1:0] hi_run_q, sel_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q  <= '0;
            sel_run_q <= TW'(GAP_CYC);
        end else begin
            hi_run_q  <= !dac_sck ? '0 : (hi_run_q == TW'(MAX_CYC)) ? hi_run_q : hi_run_q + 1'b1;
            sel_run_q <= !dac_sel_n ? '0 : (sel_run_q == TW'(GAP_CYC)) ? sel_run_q : sel_run_q + 1'b1;
        end
    end

    a_r3_sck_low_at_select_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> !dac_sck);
    a_r3_sck_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sck |-> !dac_sel_n);
    a_r4_data_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sck && $past(dac_sck)) |-> $stable(dac_sdo));
    a_r5_high_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sck) |-> (hi_run_q >= TW'(HI_CYC)));
    a_r7_load_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> (sel_run_q >= TW'(GAP_CYC)));
    a_r8_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sel_n |-> !req_ready);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/dac_serial_master_tb_top.sv
// Bench: behavioural cycle model plus measured edge spacing in nanoseconds.
module dac_serial_master_tb_top;
    localparam int CLK_NS = 20;
    localparam int L = 3, H = 3, P = 6, TAIL = 1, GAP = 5;
    localparam int TS = L + 15 * P + H + TAIL;
    localparam int BUSY_END = TS + GAP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [9:0] req_code = '0;
    logic req_ready, done, dac_sel_n, dac_sck, dac_sdo;

    int checks = 0, errors = 0;

    dac_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_code(req_code), .done(done),
        .dac_sel_n(dac_sel_n), .dac_sck(dac_sck), .dac_sdo(dac_sdo)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_min(input string req, input string what, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected>=%0d at %0t", req, what, act, lim, $time);
        end
    endtask

    // Reference model, advanced on every rising clock edge.
    bit        m_busy = 0, m_done = 0, m_acc = 0;
    int        m_t = 0;
    logic [15:0] m_word = '0;
    logic [15:0] word_q[$];

    always @(posedge clk) begin
        m_acc = 0;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_t = 0;
        end else if (!m_busy) begin
            m_done = 0;
            if (req_valid) begin
                m_busy = 1; m_t = 0; m_acc = 1;
                m_word = {req_op, req_code, 2'b00};
                word_q.push_back(m_word);
            end
        end else begin
            m_t++;
            if (m_t == BUSY_END) begin m_busy = 0; m_done = 1; end
        end
    end

    function automatic logic exp_sck();
        if (!m_busy || m_t < L || m_t >= L + 15 * P + H) return 1'b0;
        return ((m_t - L) % P) < H;
    endfunction

    function automatic logic exp_sdo();
        int k;
        if (!m_busy || m_t >= TS) return 1'b0;
        if (m_t < L + H) k = 0;
        else k = (m_t - L - H) / P + 1;
        if (k > 15) k = 15;
        return m_word[15 - k];
    endfunction

    // Edge-spacing monitor state, in negedge counts.
    int cyc = 0, t_sel_fall = -1, t_sel_rise = -1, t_rise = -1, t_fall = -1, t_sdo = 0;
    int rises = 0;
    logic [15:0] cap = '0;
    logic p_sel = 1'b1, p_sck = 1'b0, p_sdo = 1'b0;
    bit run_checks = 0;

    always @(negedge clk) begin
        cyc++;
        if (run_checks) begin
            chk("R10", "sel_n vs model", dac_sel_n, (m_busy && m_t < TS) ? 0 : 1);
            chk("R10", "sck vs model", dac_sck, exp_sck());
            chk("R2", "sdo vs model", dac_sdo, exp_sdo());
            chk("R8", "ready vs model", req_ready, !m_busy);
            chk("R9", "done vs model", done, m_done);
            if (dac_sdo !== p_sdo) t_sdo = cyc;
            if (dac_sel_n == 0 && p_sel == 1) begin
                chk("R3", "sck at select fall", dac_sck, 0);
                if (t_sel_rise >= 0) chk_min("R7", "load high ns", (cyc - t_sel_rise) * CLK_NS, 100);
                t_sel_fall = cyc; rises = 0;
            end
            if (dac_sel_n == 1) chk("R3", "sck while deselected", dac_sck, 0);
            if (dac_sck == 1 && p_sck == 0) begin
                if (rises == 0) chk_min("R4", "select to first rise ns", (cyc - t_sel_fall) * CLK_NS, 30);
                else begin
                    chk_min("R5", "low phase ns", (cyc - t_fall) * CLK_NS, 50);
                    chk_min("R5", "rise spacing ns", (cyc - t_rise) * CLK_NS, 100);
                end
                chk_min("R4", "data setup ns", (cyc - t_sdo) * CLK_NS, 60);
                cap = {cap[14:0], dac_sdo};
                rises++; t_rise = cyc;
            end
            if (dac_sck == 0 && p_sck == 1) begin
                chk_min("R5", "high phase ns", (cyc - t_rise) * CLK_NS, 50);
                t_fall = cyc;
            end
            if (dac_sel_n == 1 && p_sel == 0) begin
                logic [15:0] w;
                chk("R2", "rises per frame", rises, 16);
                chk_min("R6", "last rise to load ns", (cyc - t_rise) * CLK_NS, 50);
                w = (word_q.size() > 0) ? word_q.pop_front() : 16'hxxxx;
                chk("R2", "captured word", int'(cap), int'(w));
                t_sel_rise = cyc;
            end
        end
        p_sel = dac_sel_n; p_sck = dac_sck; p_sdo = dac_sdo;
    end

    task automatic wait_accept();
        do @(negedge clk); while (!m_acc);
    endtask

    task automatic send(input logic [3:0] op, input logic [9:0] code, input bit keep);
        req_valid = 1'b1; req_op = op; req_code = code;
        wait_accept();
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1", "sel_n in reset", dac_sel_n, 1);
        chk("R1", "sck in reset", dac_sck, 0);
        chk("R1", "sdo in reset", dac_sdo, 0);
        chk("R1", "ready in reset", req_ready, 1);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_checks = 1;
        repeat (4) @(negedge clk);

        // Single frame, mixed bits (R2, R4, R5, R6)
        send(4'b1001, 10'h2A5, 0);
        wait_idle();
        repeat (7) @(negedge clk);

        // R8: scramble inputs and pulse valid while busy, no effect on frame
        send(4'b1110, 10'h3FF, 0);
        req_op = 4'b0001; req_code = 10'h000;
        repeat (20) @(negedge clk);
        req_op = 4'b0110; req_code = 10'h155;
        req_valid = 1'b1;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);

        // R10, R7, R9: back-to-back requests with valid held high
        send(4'b0000, 10'h000, 1);
        req_op = 4'b1111; req_code = 10'h3FF;
        wait_accept();
        req_op = 4'b0010; req_code = 10'h155;
        wait_accept();
        req_op = 4'b1000; req_code = 10'h201;
        wait_accept();
        req_valid = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);

        chk("R2", "all frames delivered", word_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule